// File: doc/BRIEF.md
# Selectable Ratio Clock-Enable Divider

This block turns one of several source tick streams into a slower clock-enable pulse train. Every source is a single-cycle tick that is qualified in the block's own clock domain. A source-routing bit chooses between source 0 and a source picked by an index field. A three-level ratio selection then applies:

- A divide-by-3 override has the highest priority.
- Below it, a bypass condition passes every tick straight through.
- Below that, an encoded divisor code picks one ratio from a fixed set.

A global enable suppresses the output pulses without disturbing the divider's phase or its settings.

The output is a registered one-cycle pulse, raised once every N ticks of the selected source, where N is the effective ratio. A new ratio does not take effect at once: the period that is running completes with its old ratio, so no shortened pulse interval appears. Some settings are illegal: divisor code 7, the two widest ratios when a build parameter excludes them, or a source index with no source behind it. An illegal setting raises an error flag and holds the output low. The effective ratio is returned on a readback port so that software-visible logic can report it.

Top module: `tick_ratio_mux`

## Requirements
- R1: While reset is asserted, and until the first selected source tick after reset, `div_tick` is 0.
- R2: When `by3_en` is 1 and the selected source is valid, the ratio is 3, whatever `code_en` and `div_code` hold (code 7 included).
- R3: When `by3_en` is 0 and `code_en` is 0, every tick of the selected source produces an output pulse (ratio 1).
- R4: When `by3_en` is 0 and `code_en` is 1, `div_code` selects the ratio: 0 gives 2, 1 gives 4, 2 gives 6, 3 gives 8, 4 gives 12, 5 gives 24 and 6 gives 48.
- R5: With parameter `WIDE_EN` = 0, codes 5 and 6 (under `code_en` = 1 and `by3_en` = 0) set `cfg_err` to 1, `ratio_rb` to 0 and produce no pulses. With `WIDE_EN` = 1 they are legal.
- R6: Code 7 under `code_en` = 1 and `by3_en` = 0 sets `cfg_err` to 1 and produces no pulses.
- R7: While `gate_en` is 0, no pulse appears. Re-enabling keeps the divider phase, so pulses resume on the original N-tick grid.
- R8: With `src_route` = 0, source 0 is used and `src_idx` is ignored. With `src_route` = 1, source `src_idx` is used. An index of `NSRC` or more is an error.
- R9: A ratio change takes effect only after the period already running completes with the old ratio.
- R10: Each pulse is one clock wide and appears in the clock cycle after the edge that samples the terminal source tick.
- R11: `ratio_rb` shows the effective requested ratio (1, 3 or the decoded divisor), and 0 whenever `cfg_err` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_tick | input | NSRC | One tick stream per source |
| src_route | input | 1 | 0: use source 0; 1: use source `src_idx` |
| src_idx | input | SELW | Source index used when `src_route` is 1 |
| by3_en | input | 1 | Divide-by-3 override |
| code_en | input | 1 | Use the encoded divisor instead of bypass |
| div_code | input | 3 | Encoded divisor select |
| gate_en | input | 1 | Global output enable |
| div_tick | output | 1 | One-cycle divided enable pulse |
| cfg_err | output | 1 | Current setting is illegal |
| ratio_rb | output | 6 | Effective ratio readback, 0 on error |

## Verification
The bench builds two copies side by side with three sources. One copy has `WIDE_EN` = 1, which makes the divide-by-24 and divide-by-48 periods measurable. The other has `WIDE_EN` = 0, so the same codes must give an error and no output, and the legal codes must keep their rates. The three sources tick every cycle, every second cycle and every third cycle. Each measured pulse interval therefore shows both the ratio and which source was routed.

// File: rtl/trm_pkg.sv
package trm_pkg;
  localparam int RATIO_W = 6;
  localparam int CODE_W  = 3;

  typedef logic [RATIO_W-1:0] ratio_t;
  typedef logic [CODE_W-1:0]  code_t;

  typedef struct packed {
    logic   ok;
    ratio_t n;
  } dec_t;

  // Encoded divisor table; wide entries are gated by a build option.
  function automatic dec_t code_ratio(code_t c, bit wide);
    dec_t r;
    r.ok = 1'b1;
    r.n  = ratio_t'(1);
    case (c)
      3'd0: r.n = ratio_t'(2);
      3'd1: r.n = ratio_t'(4);
      3'd2: r.n = ratio_t'(6);
      3'd3: r.n = ratio_t'(8);
      3'd4: r.n = ratio_t'(12);
      3'd5: begin r.n = ratio_t'(24); r.ok = wide; end
      3'd6: begin r.n = ratio_t'(48); r.ok = wide; end
      default: r.ok = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/trm_rst_sync.sv
module trm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/trm_src_select.sv
module trm_src_select #(
  parameter int NSRC = 3,
  parameter int SELW = 2
) (
  input  logic [NSRC-1:0] src_tick,
  input  logic            src_route,
  input  logic [SELW-1:0] src_idx,
  output logic            sel_tick,
  output logic            sel_ok
);
  logic [SELW-1:0] idx;
  logic [NSRC-1:0] hit;

  assign idx    = src_route ? src_idx : '0;
  assign sel_ok = (32'(idx) < NSRC);

  for (genvar g = 0; g < NSRC; g++) begin : g_hit
    assign hit[g] = (32'(idx) == g) && src_tick[g];
  end

  assign sel_tick = |hit;
endmodule

// File: rtl/trm_ratio_decode.sv
module trm_ratio_decode
  import trm_pkg::*;
#(
  parameter bit WIDE_EN = 1'b1
) (
  input  logic   by3_en,
  input  logic   code_en,
  input  code_t  div_code,
  output ratio_t req_n,
  output logic   req_ok
);
  dec_t coded;

  always_comb begin
    coded  = code_ratio(div_code, WIDE_EN);
    req_n  = ratio_t'(1);
    req_ok = 1'b1;
    if (by3_en) begin
      req_n = ratio_t'(3);
    end else if (code_en) begin
      req_n  = coded.n;
      req_ok = coded.ok;
    end
  end
endmodule

// File: rtl/trm_tick_counter.sv
module trm_tick_counter
  import trm_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick,
  input  logic   cfg_ok,
  input  ratio_t req_n,
  input  logic   gate_en,
  output logic   pulse
);
  ratio_t cnt_q, cnt_d;
  ratio_t act_q, act_d;
  logic   pulse_q, pulse_d;
  logic   term;

  assign term = (cnt_q == (act_q - ratio_t'(1)));

  always_comb begin
    cnt_d   = cnt_q;
    act_d   = act_q;
    pulse_d = 1'b0;
    if (!cfg_ok) begin
      cnt_d = '0;
      act_d = ratio_t'(1);
    end else if (tick) begin
      if (term) begin
        cnt_d   = '0;
        act_d   = req_n;
        pulse_d = gate_en;
      end else begin
        cnt_d = cnt_q + ratio_t'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      act_q   <= ratio_t'(1);
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      act_q   <= act_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse = pulse_q;
endmodule

// File: rtl/tick_ratio_mux.sv
module tick_ratio_mux
  import trm_pkg::*;
#(
  parameter int NSRC    = 3,
  parameter bit WIDE_EN = 1'b1,
  localparam int SELW   = (NSRC > 1) ? $clog2(NSRC + 1) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_tick,
  input  logic            src_route,
  input  logic [SELW-1:0] src_idx,
  input  logic            by3_en,
  input  logic            code_en,
  input  logic [2:0]      div_code,
  input  logic            gate_en,
  output logic            div_tick,
  output logic            cfg_err,
  output logic [5:0]      ratio_rb
);
  logic   rst_sync_n;
  logic   sel_tick;
  logic   sel_ok;
  logic   req_ok;
  logic   cfg_ok;
  ratio_t req_n;

  trm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  trm_src_select #(.NSRC(NSRC), .SELW(SELW)) u_src (
    .src_tick  (src_tick),
    .src_route (src_route),
    .src_idx   (src_idx),
    .sel_tick  (sel_tick),
    .sel_ok    (sel_ok)
  );

  trm_ratio_decode #(.WIDE_EN(WIDE_EN)) u_dec (
    .by3_en   (by3_en),
    .code_en  (code_en),
    .div_code (div_code),
    .req_n    (req_n),
    .req_ok   (req_ok)
  );

  assign cfg_ok = req_ok && sel_ok;

  trm_tick_counter u_cnt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tick    (sel_tick),
    .cfg_ok  (cfg_ok),
    .req_n   (req_n),
    .gate_en (gate_en),
    .pulse   (div_tick)
  );

  assign cfg_err  = !cfg_ok;
  assign ratio_rb = cfg_ok ? req_n : '0;
endmodule

// File: rtl/trm_chk.sv
module trm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       gate_en,
  input logic       by3_en,
  input logic       cfg_err,
  input logic [5:0] ratio_rb,
  input logic       div_tick,
  input logic       sel_tick
);
  a_r10_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    div_tick |-> $past(sel_tick));

  a_r7_gated: assert property (@(posedge clk) disable iff (!rst_n)
    div_tick |-> $past(gate_en));

  a_r5_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    div_tick |-> !$past(cfg_err));

  a_r11_err_ratio: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (ratio_rb == 6'd0));

  a_r2_by3: assert property (@(posedge clk) disable iff (!rst_n)
    (by3_en && !cfg_err) |-> (ratio_rb == 6'd3));
endmodule

bind tick_ratio_mux trm_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .gate_en  (gate_en),
  .by3_en   (by3_en),
  .cfg_err  (cfg_err),
  .ratio_rb (ratio_rb),
  .div_tick (div_tick),
  .sel_tick (sel_tick)
);

// File: tb/sim_tick_ratio_mux.sv
module sim_tick_ratio_mux;
  localparam int NSRC = 3;
  localparam int SELW = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic [NSRC-1:0] src_tick;
  logic src_route, by3_en, code_en, gate_en;
  logic [SELW-1:0] src_idx;
  logic [2:0] div_code;
  logic out0, err0, out1, err1;
  logic [5:0] rat0, rat1;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int ph = 0;
  bit done = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) ph <= (ph == 5) ? 0 : ph + 1;
  always_comb begin
    src_tick[0] = 1'b1;
    src_tick[1] = (ph % 2) == 0;
    src_tick[2] = (ph % 3) == 0;
  end

  tick_ratio_mux #(.NSRC(NSRC), .WIDE_EN(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .src_route(src_route),
    .src_idx(src_idx), .by3_en(by3_en), .code_en(code_en), .div_code(div_code),
    .gate_en(gate_en), .div_tick(out0), .cfg_err(err0), .ratio_rb(rat0));

  tick_ratio_mux #(.NSRC(NSRC), .WIDE_EN(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .src_route(src_route),
    .src_idx(src_idx), .by3_en(by3_en), .code_en(code_en), .div_code(div_code),
    .gate_en(gate_en), .div_tick(out1), .cfg_err(err1), .ratio_rb(rat1));

  // {by3, code_en, code[2:0], route, idx[1:0], ratio[5:0], err, src[1:0]}
  localparam logic [16:0] VEC [14] = '{
    {1'b0, 1'b0, 3'd0, 1'b0, 2'd0, 6'd1,  1'b0, 2'd0},
    {1'b0, 1'b1, 3'd0, 1'b0, 2'd0, 6'd2,  1'b0, 2'd0},
    {1'b0, 1'b1, 3'd1, 1'b0, 2'd0, 6'd4,  1'b0, 2'd0},
    {1'b0, 1'b1, 3'd2, 1'b1, 2'd1, 6'd6,  1'b0, 2'd1},
    {1'b0, 1'b1, 3'd3, 1'b1, 2'd2, 6'd8,  1'b0, 2'd2},
    {1'b0, 1'b1, 3'd4, 1'b0, 2'd0, 6'd12, 1'b0, 2'd0},
    {1'b0, 1'b1, 3'd5, 1'b0, 2'd0, 6'd24, 1'b0, 2'd0},
    {1'b0, 1'b1, 3'd6, 1'b1, 2'd1, 6'd48, 1'b0, 2'd1},
    {1'b0, 1'b1, 3'd7, 1'b0, 2'd0, 6'd0,  1'b1, 2'd0},
    {1'b1, 1'b1, 3'd7, 1'b0, 2'd0, 6'd3,  1'b0, 2'd0},
    {1'b1, 1'b0, 3'd2, 1'b1, 2'd2, 6'd3,  1'b0, 2'd2},
    {1'b0, 1'b1, 3'd1, 1'b0, 2'd2, 6'd4,  1'b0, 2'd0},
    {1'b0, 1'b1, 3'd1, 1'b1, 2'd3, 6'd0,  1'b1, 2'd0},
    {1'b0, 1'b0, 3'd0, 1'b1, 2'd1, 6'd1,  1'b0, 2'd1}
  };

  function automatic string vtag(int i);
    case (i)
      0, 13:    return "R3";
      8:        return "R6";
      9, 10:    return "R2";
      11, 12:   return "R8";
      default:  return "R4";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_pulse(output int t);
    t = -1;
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk);
      if (out0) begin
        t = cyc;
        return;
      end
    end
  endtask

  task automatic count_win(input int n, output int c0, output int c1);
    c0 = 0;
    c1 = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (out0) c0++;
      if (out1) c1++;
    end
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int t0, t1, t2, c0, c1;
    bit [16:0] v;
    rst_n = 1'b0;
    src_route = 0; src_idx = 0; by3_en = 0; code_en = 1;
    div_code = 3'd1; gate_en = 1;
    repeat (4) @(negedge clk);
    chk(out0 == 1'b0, "R1 reset out", int'(out0), 0);
    chk(out1 == 1'b0, "R1 reset out u1", int'(out1), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out0 == 1'b0, "R1 after release", int'(out0), 0);

    // Table walk
    for (int i = 0; i < 14; i++) begin
      int per;
      v = VEC[i];
      @(negedge clk);
      by3_en = v[16]; code_en = v[15]; div_code = v[14:12];
      src_route = v[11]; src_idx = v[10:9];
      #1;
      chk(int'(rat0) == int'(v[8:3]), {vtag(i), " R11 ratio"}, int'(rat0), int'(v[8:3]));
      chk(err0 == v[2], {vtag(i), " err"}, int'(err0), int'(v[2]));
      if (v[2]) begin
        count_win(150, c0, c1);
        chk(c0 == 0, {vtag(i), " no pulse on error"}, c0, 0);
      end else begin
        per = int'(v[8:3]) * (int'(v[1:0]) + 1);
        wait_pulse(t0);
        wait_pulse(t0);
        wait_pulse(t1);
        chk((t1 - t0) == per, {vtag(i), " R10 period"}, t1 - t0, per);
      end
    end

    // R9: ratio change waits for running period
    @(negedge clk);
    by3_en = 0; code_en = 1; div_code = 3'd3; src_route = 0; src_idx = 0;
    wait_pulse(t0); wait_pulse(t0); wait_pulse(t0);
    repeat (2) @(negedge clk);
    div_code = 3'd0;
    #1;
    chk(rat0 == 6'd2, "R11 ratio after change", int'(rat0), 2);
    wait_pulse(t1);
    chk((t1 - t0) == 8, "R9 old period completes", t1 - t0, 8);
    wait_pulse(t2);
    chk((t2 - t1) == 2, "R9 new period", t2 - t1, 2);

    // R7: gating keeps phase
    div_code = 3'd1;
    wait_pulse(t0); wait_pulse(t0); wait_pulse(t0);
    gate_en = 0;
    count_win(21, c0, c1);
    chk(c0 == 0, "R7 gated quiet", c0, 0);
    gate_en = 1;
    wait_pulse(t1);
    chk(((t1 - t0) % 4) == 0, "R7 phase kept", (t1 - t0) % 4, 0);
    wait_pulse(t2);
    chk((t2 - t1) == 4, "R7 period after enable", t2 - t1, 4);

    // R5: wide codes on both builds
    @(negedge clk);
    div_code = 3'd5;
    #1;
    chk(err1 == 1'b1, "R5 wide code err u1", int'(err1), 1);
    chk(rat1 == 6'd0, "R5 wide code ratio u1", int'(rat1), 0);
    chk(rat0 == 6'd24, "R5 wide code ratio u0", int'(rat0), 24);
    count_win(150, c0, c1);
    chk(c1 == 0, "R5 wide code quiet u1", c1, 0);
    div_code = 3'd6;
    #1;
    chk(err1 == 1'b1, "R5 code6 err u1", int'(err1), 1);
    div_code = 3'd4;
    count_win(60, c0, c1);
    count_win(240, c0, c1);
    chk(c1 == 20, "R5 legal code on narrow build", c1, 20);
    chk(c0 == 20, "R4 divide by 12 count", c0, 20);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule